// File: doc/BRIEF.md
# Floating-Point Exception Status Controller

This block holds the status and exception state of a floating-point coprocessor. The arithmetic datapath reports a fault with a one-hot strobe and the address of the instruction that caused it. The controller decides whether the fault is armed and, if so, chooses one winner when several strobes arrive together. For the winner it sets a sticky error flag, stores a 4-bit exception code and the faulting address, and raises a level interrupt request. All floating-point faults share one interrupt vector.

Software reaches the state through one status-word load port. That word carries the mode bits, the condition codes, the per-exception enables, a global interrupt disable and the error flag. The code and address registers can only be read and have no write path. The error flag survives a system reset, so only an explicit status load clears it.

Top module: `fpx_status_ctrl`

## Requirements
- R1: While `rst_n` is low, the condition codes, mode bits, enables, global disable, exception code, exception address and `irq_req` all go to zero. The error flag (`stat_word[15]`) keeps its value through reset.
- R2: A cycle with `ld_en` high writes `ld_word` into the status word, visible on `stat_word` one cycle later. The layout is: bits 3:0 condition codes (carry, overflow, zero, negative), bits 6:4 modes (round, long integer, double), bits 10:7 enables, bit 11 global disable, bit 15 error flag. Bits 14:12 always read zero.
- R3: A strobe on `exc_vld[0]` (illegal opcode) or `exc_vld[1]` (divide by zero) always sets the error flag and captures the code and `exc_pc`, whatever the enables hold.
- R4: `exc_vld[2]` (conversion failure), `exc_vld[3]` (overflow), `exc_vld[4]` (underflow) and `exc_vld[5]` (undefined variable) take effect only when their enable is set. The enables are in status bits 7, 8, 9 and 10 respectively. A disabled strobe changes neither the flag, the code, the address nor `irq_req`.
- R5: The captured code is 2 for opcode, 4 for divide by zero, 6 for conversion, 8 for overflow, 10 for underflow and 12 for undefined variable.
- R6: When several armed strobes arrive in one cycle, the one with the lowest code is captured. Strobes that are not armed take no part in the choice.
- R7: No exception ever clears the error flag. Only a status load with bit 15 low clears it.
- R8: An armed exception raises `irq_req` on the next cycle when the global disable is clear. The request then stays high until a cycle with `irq_ack`. A new armed exception in the same cycle as the acknowledge keeps the request high.
- R9: With the global disable (bit 11) set, `irq_req` stays low, but the error flag, code and address still update as in R3 and R4.
- R10: `irq_vec` always reads octal 244.
- R11: The code and address registers do not change in a cycle without an armed exception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset (the error flag is not reset) |
| exc_vld | input | 6 | Exception strobes from the datapath, one bit per kind |
| exc_pc | input | AW | Address of the instruction reporting the exception |
| ld_en | input | 1 | Status-word load strobe |
| ld_word | input | 16 | Value to load into the status word |
| irq_ack | input | 1 | One-cycle acknowledge that clears the interrupt request |
| stat_word | output | 16 | Current status word |
| exc_code | output | 4 | Last captured exception code |
| exc_addr | output | AW | Last captured faulting address |
| irq_req | output | 1 | Level interrupt request |
| irq_vec | output | 9 | Shared interrupt vector address |

## Verification
The hardest state to reach is a cycle where the captured code must not move even though a strobe arrived. A disabled overflow that arrives together with an enabled underflow is one case. A disabled strobe that arrives while the error flag is already set is another. The bench gets there by loading a status word with a chosen subset of enables and then firing mixed strobe vectors. It also checks an acknowledge that coincides with a new fault, and it pulses reset while the error flag is held high to show that the flag survives reset.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int NUM_EXC = 6;
    localparam int STAT_W  = 16;
    localparam int CODE_W  = 4;
    localparam int VEC_W   = 9;
    localparam logic [VEC_W-1:0] VEC_ADDR = 9'o244;

    // strobe index order equals ascending code order (lowest wins)
    localparam int EX_OPC   = 0;
    localparam int EX_DIV0  = 1;
    localparam int EX_CONV  = 2;
    localparam int EX_OVF   = 3;
    localparam int EX_UNF   = 4;
    localparam int EX_UNDEF = 5;
    localparam int NUM_ARMABLE = NUM_EXC - 2;

    function automatic logic [CODE_W-1:0] code_of(input int idx);
        return CODE_W'(2 * (idx + 1));
    endfunction
endpackage

// File: rtl/fpx_prio.sv
module fpx_prio
    import fpx_pkg::*;
#(
    parameter int N  = NUM_EXC,
    parameter int CW = CODE_W
) (
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  arm,
    output logic [N-1:0]  grant,
    output logic          fire,
    output logic [CW-1:0] code
);
    logic [N-1:0] qual;
    logic [N:0]   seen;

    assign qual    = req & arm;
    assign seen[0] = 1'b0;

    for (genvar g = 0; g < N; g++) begin : g_chain
        assign grant[g]  = qual[g] & ~seen[g];
        assign seen[g+1] = seen[g] | qual[g];
    end

    assign fire = seen[N];

    always_comb begin
        code = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) code = code | CW'(2 * (i + 1));
        end
    end

    always_comb begin
        AST_ONE_WINNER: assert ($onehot0(grant)); // R6
    end
endmodule

// File: rtl/fpx_irq.sv
module fpx_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic mask,
    input  logic ack,
    output logic req
);
    logic req_d, req_q;

    always_comb begin
        req_d = req_q;
        if (ack)          req_d = 1'b0;
        if (set && !mask) req_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req_d;
    end

    assign req = req_q;

    AST_IRQ_HOLD:   assert property (@(posedge clk) disable iff (!rst_n)
                        (req_q && !ack) |=> req_q); // R8
    AST_IRQ_RISE:   assert property (@(posedge clk) disable iff (!rst_n)
                        (set && !mask) |=> req_q); // R8
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
                        (!req_q && mask) |=> !req_q); // R9
endmodule

// File: rtl/fpx_status_ctrl.sv
module fpx_status_ctrl
    import fpx_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_EXC-1:0]  exc_vld,
    input  logic [AW-1:0]       exc_pc,
    input  logic                ld_en,
    input  logic [STAT_W-1:0]   ld_word,
    input  logic                irq_ack,
    output logic [STAT_W-1:0]   stat_word,
    output logic [CODE_W-1:0]   exc_code,
    output logic [AW-1:0]       exc_addr,
    output logic                irq_req,
    output logic [VEC_W-1:0]    irq_vec
);
    typedef struct packed {
        logic [3:0]             cc;
        logic [2:0]             mode;
        logic [NUM_ARMABLE-1:0] en;
        logic                   gdis;
        logic [CODE_W-1:0]      code;
        logic [AW-1:0]          addr;
    } state_t;

    state_t s_d, s_q;
    logic   err_d, err_q;

    logic [NUM_EXC-1:0] arm, grant;
    logic               fire;
    logic [CODE_W-1:0]  win_code;

    // divide-by-zero and opcode faults are always armed
    assign arm = {s_q.en, 2'b11};

    fpx_prio #(.N(NUM_EXC), .CW(CODE_W)) u_prio (
        .req   (exc_vld),
        .arm   (arm),
        .grant (grant),
        .fire  (fire),
        .code  (win_code)
    );

    fpx_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (fire),
        .mask  (s_q.gdis),
        .ack   (irq_ack),
        .req   (irq_req)
    );

    always_comb begin
        s_d   = s_q;
        err_d = err_q;
        if (ld_en) begin
            s_d.cc   = ld_word[3:0];
            s_d.mode = ld_word[6:4];
            s_d.en   = ld_word[10:7];
            s_d.gdis = ld_word[11];
            err_d    = ld_word[15];
        end
        if (fire) begin
            err_d    = 1'b1;
            s_d.code = win_code;
            s_d.addr = exc_pc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // error flag is deliberately outside the system reset
    always_ff @(posedge clk) begin
        err_q <= err_d;
    end

    assign stat_word = {err_q, 3'b000, s_q.gdis, s_q.en, s_q.mode, s_q.cc};
    assign exc_code  = s_q.code;
    assign exc_addr  = s_q.addr;
    assign irq_vec   = VEC_ADDR;

    AST_ERR_STICKY:   assert property (@(posedge clk) disable iff (!rst_n)
                          (err_q && !ld_en) |=> err_q); // R7
    AST_ERR_ON_FIRE:  assert property (@(posedge clk) disable iff (!rst_n)
                          fire |=> stat_word[15]); // R3
    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                          !fire |=> ($stable(exc_code) && $stable(exc_addr))); // R11
    AST_CODE_LEGAL:   assert property (@(posedge clk) disable iff (!rst_n)
                          fire |=> (exc_code != 4'd0 && !exc_code[0] && exc_code <= 4'd12)); // R5
endmodule

// File: tb/tb_fpx_status_ctrl.sv
`timescale 1ns/1ps
module tb_fpx_status_ctrl;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [5:0]    exc_vld = '0;
    logic [AW-1:0] exc_pc = '0;
    logic          ld_en = 1'b0;
    logic [15:0]   ld_word = '0;
    logic          irq_ack = 1'b0;
    logic [15:0]   stat_word;
    logic [3:0]    exc_code;
    logic [AW-1:0] exc_addr;
    logic          irq_req;
    logic [8:0]    irq_vec;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    fpx_status_ctrl #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .exc_vld(exc_vld), .exc_pc(exc_pc),
        .ld_en(ld_en), .ld_word(ld_word), .irq_ack(irq_ack),
        .stat_word(stat_word), .exc_code(exc_code), .exc_addr(exc_addr),
        .irq_req(irq_req), .irq_vec(irq_vec)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // inputs change at falling edges; results sampled at the next falling edge
    task automatic do_load(input logic [15:0] w);
        @(negedge clk); ld_en = 1'b1; ld_word = w;
        @(negedge clk); ld_en = 1'b0; ld_word = '0;
    endtask

    task automatic do_exc(input logic [5:0] v, input logic [AW-1:0] pc);
        @(negedge clk); exc_vld = v; exc_pc = pc;
        @(negedge clk); exc_vld = '0; exc_pc = '0;
    endtask

    task automatic do_ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 status", 32'(stat_word & 16'h7FFF), 32'h0);
        check("R1 code", 32'(exc_code), 32'h0);
        check("R1 addr", 32'(exc_addr), 32'h0);
        check("R1 irq", 32'(irq_req), 32'h0);
        check("R10 vector", 32'(irq_vec), 32'o244);
        do_load(16'h0000);
        check("R2 clear", 32'(stat_word), 32'h0);
    endtask

    task automatic t_load();
        do_load(16'hFFFF);
        check("R2 all ones", 32'(stat_word), 32'h8FFF);
        do_load(16'h0075);
        check("R2 cc and modes", 32'(stat_word), 32'h0075);
        do_load(16'h0000);
        check("R2 zero", 32'(stat_word), 32'h0);
    endtask

    task automatic t_reset_keeps_err();
        do_load(16'h8F35);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 err kept", 32'(stat_word), 32'h8000);
        do_load(16'h0000);
        check("R7 cleared by load", 32'(stat_word[15]), 32'h0);
    endtask

    task automatic t_always_armed();
        do_exc(6'b000010, 16'h1234);
        check("R3 div0 err", 32'(stat_word[15]), 32'h1);
        check("R5 div0 code", 32'(exc_code), 32'd4);
        check("R3 div0 addr", 32'(exc_addr), 32'h1234);
        check("R8 irq rise", 32'(irq_req), 32'h1);
        repeat (3) @(negedge clk);
        check("R8 irq held", 32'(irq_req), 32'h1);
        do_ack();
        check("R8 irq acked", 32'(irq_req), 32'h0);
        do_load(16'h0000);
        do_exc(6'b000001, 16'h0102);
        check("R5 opcode code", 32'(exc_code), 32'd2);
        check("R3 opcode addr", 32'(exc_addr), 32'h0102);
        do_ack();
        do_load(16'h0000);
    endtask

    task automatic t_disabled();
        for (int i = 2; i < 6; i++) begin
            do_exc(6'(1 << i), 16'hBEEF);
            check("R4 disabled err", 32'(stat_word[15]), 32'h0);
            check("R11 code held", 32'(exc_code), 32'd2);
            check("R11 addr held", 32'(exc_addr), 32'h0102);
            check("R4 disabled irq", 32'(irq_req), 32'h0);
        end
    endtask

    task automatic t_enabled();
        for (int i = 2; i < 6; i++) begin
            do_load(16'(1 << (i + 5)));
            do_exc(6'(1 << i), 16'(16'h2000 + i));
            check("R4 armed err", 32'(stat_word[15]), 32'h1);
            check("R5 armed code", 32'(exc_code), 32'(2 * (i + 1)));
            check("R4 armed addr", 32'(exc_addr), 32'(16'h2000 + i));
            check("R8 armed irq", 32'(irq_req), 32'h1);
            do_ack();
            do_load(16'h0000);
        end
    endtask

    task automatic t_priority();
        do_load(16'h0780);
        do_exc(6'b111100, 16'h3000);
        check("R6 conv wins", 32'(exc_code), 32'd6);
        do_exc(6'b111111, 16'h3001);
        check("R6 opcode wins", 32'(exc_code), 32'd2);
        do_load(16'h0680);
        do_exc(6'b011000, 16'h3002);
        check("R6 disabled ovf skipped", 32'(exc_code), 32'd10);
        check("R6 addr", 32'(exc_addr), 32'h3002);
        do_ack();
        do_load(16'h0000);
    endtask

    task automatic t_global_disable();
        do_load(16'h0F80);
        do_exc(6'b001000, 16'h4444);
        check("R9 err still set", 32'(stat_word[15]), 32'h1);
        check("R9 code still set", 32'(exc_code), 32'd8);
        check("R9 addr still set", 32'(exc_addr), 32'h4444);
        check("R9 irq masked", 32'(irq_req), 32'h0);
        do_exc(6'b000010, 16'h4445);
        check("R9 div0 masked", 32'(irq_req), 32'h0);
        do_load(16'h0000);
    endtask

    task automatic t_ack_race();
        do_exc(6'b000010, 16'h5000);
        check("R8 raised", 32'(irq_req), 32'h1);
        @(negedge clk); irq_ack = 1'b1; exc_vld = 6'b000001; exc_pc = 16'h5001;
        @(negedge clk); irq_ack = 1'b0; exc_vld = '0; exc_pc = '0;
        check("R8 ack vs new fault", 32'(irq_req), 32'h1);
        check("R5 race code", 32'(exc_code), 32'd2);
        do_ack();
        check("R8 final ack", 32'(irq_req), 32'h0);
    endtask

    task automatic t_sticky();
        repeat (4) @(negedge clk);
        check("R7 flag idle", 32'(stat_word[15]), 32'h1);
        do_exc(6'b100000, 16'h6000);
        check("R7 flag after disabled fault", 32'(stat_word[15]), 32'h1);
        check("R11 code untouched", 32'(exc_code), 32'd2);
        check("R11 addr untouched", 32'(exc_addr), 32'h5001);
        do_load(16'h0000);
        check("R7 load clears", 32'(stat_word[15]), 32'h0);
    endtask

    initial begin
        t_reset();
        t_load();
        t_reset_keeps_err();
        t_always_armed();
        t_disabled();
        t_enabled();
        t_priority();
        t_global_disable();
        t_ack_race();
        t_sticky();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule